// File: doc/BRIEF.md
# PWM Dead Band Generator

This block takes one pulse-width-modulated reference and produces two complementary drive outputs that are never high together. On every reference transition both outputs drop low. An 8-bit down counter then times a programmable gap, and only after the gap has run out does the output that matches the new reference level rise. The primary output follows the high phase of the reference and the auxiliary output follows its low phase.

Software reaches the block through a small register port with four locations: a count location (the down counter, which is not directly readable), a write-only period, a buffer, and a 3-bit control register. The period sets the gap length to period + 1 clocks. While the block is disabled, the counter holds still, a period write also loads the counter, and reading the count location copies the live count into the buffer. A kill bit in the control register forces both outputs low.

Top module: `db_deadband_gen`

## Requirements
- R1: After reset both outputs are low, the control register reads 0 and the buffer reads 00h.
- R2: Register addresses are 0 = count, 1 = period, 2 = buffer and 3 = control. Control bit 0 is enable, bit 1 is kill and bit 2 is a spare bit that is stored and read back. Reads of the count and period addresses always return 00h. Writes to the count and buffer addresses have no effect.
- R3: While disabled, both outputs are low and the counter keeps its value whatever the reference does.
- R4: While disabled, a period write also loads the written value into the counter in the same cycle.
- R5: While disabled, a read of the count address copies the counter into the buffer. While enabled, such a read leaves the buffer unchanged.
- R6: While enabled, the first clock edge after a reference transition drives both outputs low and loads the counter from the period. After period + 1 clocks, the primary output rises if the reference is high and the auxiliary output rises if it is low.
- R7: A period of 00h gives a gap of exactly one clock, and FFh gives 256 clocks.
- R8: A reference transition during a gap restarts the gap from the period, and both outputs stay low throughout.
- R9: The primary and auxiliary outputs are never high in the same cycle.
- R10: While kill is set, both outputs are low. When kill is cleared outside a gap, the output for the current level rises again on the next clock.
- R11: A period write during a gap does not change that gap. The new value sets the length of the following gaps.
- R12: On enabling, the counter counts down from the value it holds. The output for the current level rises after that value + 1 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid while bus_rd is high |
| ref_in | input | 1 | PWM reference, synchronous to clk |
| out_pri | output | 1 | Drive output for the reference high phase |
| out_aux | output | 1 | Drive output for the reference low phase |

## Verification
A counter that is loaded wrongly or decremented wrongly shows up as a gap that is one or more clocks too long or too short. This appears at the next rising output, within period + 1 clocks of the transition. A lost restart shows up as an output that rises too early after a quick double transition. A broken freeze or snapshot path is exposed by reading the buffer right after a disabled-state count read, so the wrong value is visible on the bus in the next cycle. Overlap or kill faults appear in the same cycle as a forbidden high level on an output.

// File: rtl/db_pkg.sv
package db_pkg;
   typedef enum logic [1:0] {
      ADDR_COUNT  = 2'd0,
      ADDR_PERIOD = 2'd1,
      ADDR_BUFFER = 2'd2,
      ADDR_CTRL   = 2'd3
   } db_addr_e;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_KILL_BIT = 1;
   localparam int LEVEL_LOW     = 0;
   localparam int LEVEL_HIGH    = 1;
endpackage

// File: rtl/db_regs.sv
module db_regs
   import db_pkg::*;
#(
   parameter int DW = 8,
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic          rd,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] cnt_value,
   output logic [DW-1:0] period,
   output logic [DW-1:0] buffer,
   output logic          en,
   output logic          kill,
   output logic          period_load,
   output logic [DW-1:0] rdata
);
   logic [CW-1:0] ctrl_q;
   logic [DW-1:0] period_q;
   logic [DW-1:0] buffer_q;
   logic          snap;

   assign en          = ctrl_q[CTRL_EN_BIT];
   assign kill        = ctrl_q[CTRL_KILL_BIT];
   assign period_load = wr && (addr == ADDR_PERIOD) && !en;
   assign snap        = rd && (addr == ADDR_COUNT) && !en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         period_q <= '0;
         buffer_q <= '0;
      end else begin
         if (wr && addr == ADDR_CTRL)   ctrl_q   <= wdata[CW-1:0];
         if (wr && addr == ADDR_PERIOD) period_q <= wdata;
         if (snap)                      buffer_q <= cnt_value;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (addr)
            ADDR_BUFFER: rdata = buffer_q;
            ADDR_CTRL:   rdata = DW'(ctrl_q);
            default:     rdata = '0;
         endcase
      end
   end

   assign period = period_q;
   assign buffer = buffer_q;
endmodule

// File: rtl/db_timer.sv
module db_timer #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          ref_in,
   input  logic [DW-1:0] period,
   input  logic          period_load,
   input  logic [DW-1:0] load_value,
   output logic [DW-1:0] cnt,
   output logic          busy,
   output logic          ref_q
);
   logic          edge_seen;
   logic          term;
   logic [DW-1:0] cnt_q;

   assign edge_seen = (ref_in != ref_q);
   assign term      = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         busy  <= 1'b1;
         ref_q <= 1'b0;
      end else if (!en) begin
         ref_q <= ref_in;
         busy  <= 1'b1;
         if (period_load) cnt_q <= load_value;
      end else if (edge_seen) begin
         ref_q <= ref_in;
         busy  <= 1'b1;
         cnt_q <= period;
      end else if (busy) begin
         if (term) begin
            busy  <= 1'b0;
            cnt_q <= period;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/db_outstage.sv
module db_outstage
   import db_pkg::*;
#(
   parameter int N_OUT = 2
) (
   input  logic             en,
   input  logic             kill,
   input  logic             busy,
   input  logic             level,
   output logic [N_OUT-1:0] drive
);
   logic release_ok;
   assign release_ok = en && !kill && !busy;

   for (genvar i = 0; i < N_OUT; i++) begin : g_phase
      if (i == LEVEL_HIGH) begin : g_hi
         assign drive[i] = release_ok && level;
      end else begin : g_lo
         assign drive[i] = release_ok && !level;
      end
   end
endmodule

// File: rtl/db_deadband_gen.sv
module db_deadband_gen
   import db_pkg::*;
#(
   parameter int DW = 8,
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [1:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          ref_in,
   output logic          out_pri,
   output logic          out_aux
);
   localparam int N_OUT = 2;

   if (DW < 2) begin : g_bad_dw
      $error("db_deadband_gen: DW must be at least 2");
   end
   if (CW < 2 || CW > DW) begin : g_bad_cw
      $error("db_deadband_gen: CW must lie between 2 and DW");
   end

   logic [DW-1:0]    period_w;
   logic [DW-1:0]    buffer_w;
   logic [DW-1:0]    cnt_w;
   logic             en_w;
   logic             kill_w;
   logic             load_w;
   logic             busy_w;
   logic             level_w;
   logic [N_OUT-1:0] drive_w;

   db_regs #(.DW(DW), .CW(CW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
      .wdata(bus_wdata), .cnt_value(cnt_w), .period(period_w), .buffer(buffer_w),
      .en(en_w), .kill(kill_w), .period_load(load_w), .rdata(bus_rdata)
   );

   db_timer #(.DW(DW)) u_timer (
      .clk(clk), .rst_n(rst_n), .en(en_w), .ref_in(ref_in), .period(period_w),
      .period_load(load_w), .load_value(bus_wdata), .cnt(cnt_w), .busy(busy_w),
      .ref_q(level_w)
   );

   db_outstage #(.N_OUT(N_OUT)) u_out (
      .en(en_w), .kill(kill_w), .busy(busy_w), .level(level_w), .drive(drive_w)
   );

   assign out_pri = drive_w[LEVEL_HIGH];
   assign out_aux = drive_w[LEVEL_LOW];
endmodule

// File: rtl/db_deadband_chk.sv
module db_deadband_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_rd,
   input logic [1:0]    bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic [DW-1:0] bus_rdata,
   input logic          ref_in,
   input logic          out_pri,
   input logic          out_aux,
   input logic          en,
   input logic          kill,
   input logic          load,
   input logic          busy,
   input logic          level,
   input logic [DW-1:0] cnt,
   input logic [DW-1:0] period,
   input logic [DW-1:0] buffer
);
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_pri && out_aux)); // R9
   AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!out_pri && !out_aux)); // R3
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> $stable(cnt)); // R3
   AST_KILL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      kill |-> (!out_pri && !out_aux)); // R10
   AST_DIS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && load) |=> (cnt == $past(bus_wdata))); // R4
   AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && bus_rd && bus_addr == 2'd0) |=> (buffer == $past(cnt))); // R5
   AST_COUNT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 2'd0) |-> (bus_rdata == '0)); // R2
   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ref_in != level) |=> (busy && cnt == $past(period))); // R8
   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (en && busy && ref_in == level && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R6
   AST_TC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && busy && ref_in == level && cnt == '0) |=> !busy); // R7
endmodule

bind db_deadband_gen db_deadband_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_in(ref_in),
   .out_pri(out_pri), .out_aux(out_aux), .en(en_w), .kill(kill_w),
   .load(load_w), .busy(busy_w), .level(level_w), .cnt(cnt_w),
   .period(period_w), .buffer(buffer_w)
);

// File: tb/db_deadband_gen_tb.sv
module db_deadband_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       ref_in = 1'b0;
   logic       out_pri;
   logic       out_aux;

   int checks = 0;
   int fails = 0;
   int overlaps = 0;

   always #5 clk = ~clk;

   db_deadband_gen u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ref_in(ref_in), .out_pri(out_pri), .out_aux(out_aux)
   );

   // each entry: {new reference level, period}
   localparam logic [8:0] VEC [6] = '{
      {1'b1, 8'd0}, {1'b0, 8'd1}, {1'b1, 8'd3},
      {1'b0, 8'd7}, {1'b1, 8'd0}, {1'b0, 8'd255}
   };

   always @(negedge clk) if (out_pri && out_aux) overlaps++;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic measure_gap(output int n);
      n = 0;
      while (!out_pri && !out_aux && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] rv;
      int gap;
      int n;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!out_pri && !out_aux, "R1 outputs", {out_pri, out_aux}, 0);
      bus_read(2'd3, rv); check(rv == 8'd0, "R1 control", rv, 0);
      bus_read(2'd2, rv); check(rv == 8'd0, "R1 buffer", rv, 0);

      // R2 map: spare control bit read back, period write-only
      bus_write(2'd3, 8'h04);
      bus_read(2'd3, rv); check(rv == 8'h04, "R2 control spare", rv, 4);
      bus_write(2'd1, 8'h5A);
      bus_read(2'd1, rv); check(rv == 8'd0, "R2 period reads zero", rv, 0);
      bus_write(2'd2, 8'h33);
      bus_read(2'd2, rv); check(rv == 8'd0, "R2 buffer write ignored", rv, 0);
      // R4 and R5: disabled period write loaded counter; count read snapshots
      bus_read(2'd0, rv); check(rv == 8'd0, "R5 count read zero", rv, 0);
      bus_read(2'd2, rv); check(rv == 8'h5A, "R4 snapshot of loaded count", rv, 'h5A);
      bus_write(2'd3, 8'h00);

      // R3 disabled: outputs low and counter frozen while reference toggles
      for (int i = 0; i < 6; i++) begin
         ref_in = ~ref_in;
         @(negedge clk);
         check(!out_pri && !out_aux, "R3 disabled outputs", {out_pri, out_aux}, 0);
      end
      bus_read(2'd0, rv);
      bus_read(2'd2, rv); check(rv == 8'h5A, "R3 frozen count", rv, 'h5A);

      // R12 enable starts from loaded count 5Ah
      ref_in = 1'b0;
      @(negedge clk);
      bus_write(2'd3, 8'h01);
      measure_gap(gap);
      check(gap == 91, "R12 first gap", gap, 91);
      check(out_aux && !out_pri, "R12 low level output", {out_pri, out_aux}, 1);

      // R5 enabled read leaves buffer alone
      bus_read(2'd0, rv); check(rv == 8'd0, "R5 enabled count read", rv, 0);
      bus_read(2'd2, rv); check(rv == 8'h5A, "R5 enabled no snapshot", rv, 'h5A);

      // R6 and R7 vector walk
      for (int v = 0; v < 6; v++) begin
         bus_write(2'd1, VEC[v][7:0]);
         ref_in = VEC[v][8];
         @(negedge clk);
         measure_gap(gap);
         check(gap == int'(VEC[v][7:0]) + 1, "R7 gap length", gap, int'(VEC[v][7:0]) + 1);
         check(out_pri == VEC[v][8] && out_aux == !VEC[v][8], "R6 output phase",
               {out_pri, out_aux}, VEC[v][8] ? 2 : 1);
      end

      // R8 retrigger within a gap
      bus_write(2'd1, 8'd5);
      ref_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(!out_pri && !out_aux, "R8 low before retrigger", {out_pri, out_aux}, 0);
      @(negedge clk);
      ref_in = 1'b0;
      @(negedge clk);
      measure_gap(gap);
      check(gap == 6, "R8 restarted gap", gap, 6);
      check(out_aux && !out_pri, "R8 output after restart", {out_pri, out_aux}, 1);

      // R11 period write during a gap
      bus_write(2'd1, 8'd10);
      ref_in = 1'b1;
      @(negedge clk);
      n = 0;
      while (!out_pri && !out_aux && n < 1000) begin
         if (n == 3) begin
            bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'd2;
         end else if (n == 4) begin
            bus_wr = 1'b0;
         end
         n++;
         @(negedge clk);
      end
      bus_wr = 1'b0;
      check(n == 11, "R11 running gap unchanged", n, 11);
      ref_in = 1'b0;
      @(negedge clk);
      measure_gap(gap);
      check(gap == 3, "R11 next gap uses new period", gap, 3);

      // R10 kill
      bus_write(2'd3, 8'h03);
      for (int i = 0; i < 3; i++) begin
         check(!out_pri && !out_aux, "R10 kill low", {out_pri, out_aux}, 0);
         @(negedge clk);
      end
      bus_write(2'd3, 8'h01);
      check(out_aux && !out_pri, "R10 release after kill", {out_pri, out_aux}, 1);

      // R3 disable drops outputs
      bus_write(2'd3, 8'h00);
      check(!out_pri && !out_aux, "R3 disable drops outputs", {out_pri, out_aux}, 0);

      check(overlaps == 0, "R9 overlap count", overlaps, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule